// File: doc/BRIEF.md
# Flash Byte-Program and Chip-Erase Sequencer

This block sits on the host side of an 8-bit parallel NOR flash bus. A client hands it one request: a byte program (target address and data) or a whole-chip erase. The block writes the unlock and command cycles, with strobe widths and recovery gaps counted in clock cycles. It then reads the device status until the embedded operation is judged finished, and returns a single pass/fail verdict.

Two completion algorithms are available, chosen per request. The first compares the polarity bit of the status with the expected data. The second watches the toggling bit across back-to-back reads. In both, once the device raises its error flag, the block makes one more check before it declares a failure. This covers the case where the operation finishes just as the flag appears. A read budget bounds the polling. After any failure the block writes the reset command so that the device returns to array reads, and only then reports.

Top module: `flash_op_ctrl`

## Requirements
- R1: A request on `req_valid` is taken only while `busy` is low. `busy` is high from the cycle after acceptance until the cycle `done` pulses. A request raised while `busy` is high adds no bus cycle and changes no result.
- R2: A program request writes, in order, AAh to 555h, 55h to 2AAh, A0h to 555h, and then the request data to the request address.
- R3: An erase request writes, in order, AAh to 555h, 55h to 2AAh, 80h to 555h, AAh to 555h, 55h to 2AAh, and 10h to 555h.
- R4: In every write cycle, chip enable is low and output enable is high. Address and data do not change while write enable is low. Write enable stays low for exactly `WR_LOW` cycles. Between two writes of one request it stays high for at least `WR_HIGH` cycles.
- R5: Polarity mode (`req_toggle`=0). Status reads use the request address. The expected bit 7 is data bit 7 for a program and 1 for an erase. If a read's bit 7 matches, the result is pass. If not and bit 5 is 0, the block reads again. If not and bit 5 is 1, the block makes one confirm read and passes only if that read's bit 7 matches.
- R6: Toggle mode (`req_toggle`=1). Reads come in pairs. An unchanged bit 6 across a pair gives pass. If bit 6 changed and bit 5 of the second read is 0, a new pair follows. If bit 5 is 1, one more pair is read, and the result is fail if bit 6 still changes, otherwise pass.
- R7: Before reporting a failed result, the block writes F0h to address 0. After a pass, no such write occurs.
- R8: If `poll_limit` status reads (value at least 1) complete without a verdict, the result is fail.
- R9: `done` is a single-cycle pulse. `pass` changes only in a cycle where `done` is high.
- R10: After reset, `busy`, `done` and `pass` are low, chip, write and output enables are high, and the data bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_erase | input | 1 | 1: chip erase, 0: byte program |
| req_toggle | input | 1 | 1: toggle-bit completion, 0: polarity-bit completion |
| req_addr | input | ADDR_W | Program target / status read address |
| req_data | input | 8 | Program data |
| poll_limit | input | LIMIT_W | Maximum number of status reads |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Verdict of the last operation |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | 8 | Data driven to flash |
| fl_dq_oe | output | 1 | Host drives the data bus |
| fl_dq_in | input | 8 | Data read from flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
Some rules are checked by assertions on every cycle. These cover the exact low width of the write strobe and output enable staying high during any write. They also cover `done` being a lone pulse, `pass` holding between pulses, a verdict never arriving without a completed read, and the read budget never being overrun. Other behaviour only shows up in the bench's scenarios, where a modelled flash feeds scripted status sequences. These include the exact command bytes and addresses in order, the read counts of both algorithms, the late-completion races where the error flag shows up one read early, the timeout, the reset write after a failure, and a request ignored while busy.

// File: rtl/flash_op_pkg.sv
// Shared types and command-sequence tables for the flash program/erase
// sequencer. Assumes an 8-bit data bus and 11 decoded command address bits.
package flash_op_pkg;

    localparam int DATA_W = 8;
    localparam int CMD_AW = 11;

    typedef enum logic [2:0] {
        T_IDLE, T_CMD_GO, T_CMD_WAIT, T_POLL_GO, T_POLL_WAIT, T_RST_GO, T_RST_WAIT
    } top_st_t;

    typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STROBE, B_RECOV} bus_st_t;

    typedef enum logic [1:0] {J_IDLE, J_ISSUE, J_WAIT} jud_st_t;

    localparam logic [CMD_AW-1:0] KEY_ADDR_A = 11'h555;
    localparam logic [CMD_AW-1:0] KEY_ADDR_B = 11'h2AA;
    localparam logic [DATA_W-1:0] RESET_CMD  = 8'hF0;

    // Number of bus writes a request needs.
    function automatic logic [2:0] step_count(input logic erase);
        return erase ? 3'd6 : 3'd4;
    endfunction

    // Command address of a step; steps 1 and 4 use the second key address.
    function automatic logic [CMD_AW-1:0] step_addr(input logic [2:0] idx);
        return (idx == 3'd1 || idx == 3'd4) ? KEY_ADDR_B : KEY_ADDR_A;
    endfunction

    // Command byte of a step (program step 3 carries user data instead).
    function automatic logic [DATA_W-1:0] step_data(input logic erase, input logic [2:0] idx);
        logic [DATA_W-1:0] d;
        case (idx)
            3'd0, 3'd3: d = 8'hAA;
            3'd1, 3'd4: d = 8'h55;
            3'd2:       d = erase ? 8'h80 : 8'hA0;
            default:    d = 8'h10;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/flash_bus_cycle.sv
// Timed single bus cycle engine: one write or one read per start pulse.
// Assumes start is raised only while idle is high; all widths >= 1.
module flash_bus_cycle
    import flash_op_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int WR_LOW  = 10,
    parameter int WR_HIGH = 8,
    parameter int RD_LOW  = 14,
    parameter int RD_HIGH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              idle,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [DATA_W-1:0] fl_dq_in,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);

    localparam int MAX_A = (WR_LOW > WR_HIGH) ? WR_LOW : WR_HIGH;
    localparam int MAX_B = (RD_LOW > RD_HIGH) ? RD_LOW : RD_HIGH;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_C + 1);

    bus_st_t             st;
    logic [CNT_W-1:0]    cnt;
    logic                rd_q;
    logic [ADDR_W-1:0]   a_q;
    logic [DATA_W-1:0]   d_q;
    logic                ack_q;
    logic [DATA_W-1:0]   rdata_q;

    // Cycle phase sequencing, operand capture and read sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= B_IDLE;
            cnt     <= '0;
            rd_q    <= 1'b0;
            a_q     <= '0;
            d_q     <= '0;
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q <= 1'b0;
            case (st)
                B_IDLE: if (start) begin
                    st   <= B_SETUP;
                    rd_q <= is_rd;
                    a_q  <= addr;
                    d_q  <= wdata;
                end
                B_SETUP: begin
                    st  <= B_STROBE;
                    cnt <= rd_q ? CNT_W'(RD_LOW - 1) : CNT_W'(WR_LOW - 1);
                end
                B_STROBE: begin
                    if (cnt == '0) begin
                        st  <= B_RECOV;
                        cnt <= rd_q ? CNT_W'(RD_HIGH - 1) : CNT_W'(WR_HIGH - 1);
                        if (rd_q) rdata_q <= fl_dq_in;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        st    <= B_IDLE;
                        ack_q <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    // Pin decode from the current phase.
    always_comb begin
        idle      = (st == B_IDLE);
        ack       = ack_q;
        rdata     = rdata_q;
        fl_addr   = a_q;
        fl_dq_out = d_q;
        fl_dq_oe  = (st != B_IDLE) && !rd_q;
        fl_ce_n   = (st == B_IDLE);
        fl_we_n   = !((st == B_STROBE) && !rd_q);
        fl_oe_n   = !((st == B_STROBE) && rd_q);
    end

    // Checker: count consecutive write-low cycles.
    logic [CNT_W:0] wl_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)        wl_cnt <= '0;
        else if (!fl_we_n) wl_cnt <= wl_cnt + 1'b1;
        else               wl_cnt <= '0;
    end

    a_r4_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (wl_cnt == (CNT_W+1)'(WR_LOW)));
    a_r4_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (fl_oe_n && !fl_ce_n && fl_dq_oe));
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

endmodule

// File: rtl/flash_poll_judge.sv
// Completion judge: requests status reads and decides pass/fail with
// either the polarity-bit or the toggle-bit algorithm, under a read budget.
// Assumes inputs mode, exp7 and limit hold steady while active.
module flash_poll_judge
    import flash_op_pkg::*;
#(
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               toggle_mode,
    input  logic               exp7,
    input  logic [LIMIT_W-1:0] limit,
    output logic               rd_start,
    input  logic               rd_ack,
    input  logic [DATA_W-1:0]  rd_data,
    output logic               fin,
    output logic               fin_pass
);

    jud_st_t            st;
    logic [1:0]         phase;
    logic               prev6;
    logic [LIMIT_W-1:0] nreads;
    logic               fin_q, pass_q;

    logic               dec_done, dec_pass;
    logic [1:0]         ph_n;
    logic [LIMIT_W:0]   nreads_n;

    // Verdict and next phase from the latest status byte.
    always_comb begin
        dec_done = 1'b0;
        dec_pass = 1'b0;
        ph_n     = phase;
        if (!toggle_mode) begin
            if (phase == 2'd0) begin
                if (rd_data[7] == exp7) begin
                    dec_done = 1'b1;
                    dec_pass = 1'b1;
                end else if (rd_data[5]) begin
                    ph_n = 2'd1;
                end
            end else begin
                dec_done = 1'b1;
                dec_pass = (rd_data[7] == exp7);
            end
        end else begin
            case (phase)
                2'd0: ph_n = 2'd1;
                2'd1: begin
                    if (rd_data[6] == prev6) begin
                        dec_done = 1'b1;
                        dec_pass = 1'b1;
                    end else if (rd_data[5]) begin
                        ph_n = 2'd2;
                    end else begin
                        ph_n = 2'd0;
                    end
                end
                2'd2: ph_n = 2'd3;
                default: begin
                    dec_done = 1'b1;
                    dec_pass = (rd_data[6] == prev6);
                end
            endcase
        end
        nreads_n = {1'b0, nreads} + 1'b1;
    end

    // Read issue / wait loop and verdict registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= J_IDLE;
            phase  <= 2'd0;
            prev6  <= 1'b0;
            nreads <= '0;
            fin_q  <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (st)
                J_IDLE: if (start) begin
                    st     <= J_ISSUE;
                    phase  <= 2'd0;
                    nreads <= '0;
                end
                J_ISSUE: st <= J_WAIT;
                default: if (rd_ack) begin
                    prev6  <= rd_data[6];
                    phase  <= ph_n;
                    nreads <= nreads_n[LIMIT_W-1:0];
                    if (dec_done) begin
                        st     <= J_IDLE;
                        fin_q  <= 1'b1;
                        pass_q <= dec_pass;
                    end else if (nreads_n >= {1'b0, limit}) begin
                        st     <= J_IDLE;
                        fin_q  <= 1'b1;
                        pass_q <= 1'b0;
                    end else begin
                        st <= J_ISSUE;
                    end
                end
            endcase
        end
    end

    assign rd_start = (st == J_ISSUE);
    assign fin      = fin_q;
    assign fin_pass = pass_q;

    a_r5_verdict_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> $past(rd_ack));
    a_r8_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && limit != '0) |-> (nreads < limit));

endmodule

// File: rtl/flash_op_ctrl.sv
// Top: accepts a program or erase request, writes the command sequence,
// runs the completion judge, writes the reset command after a failure and
// reports done/pass. Assumes the flash bus is owned solely by this block.
module flash_op_ctrl
    import flash_op_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int LIMIT_W = 16,
    parameter int WR_LOW  = 10,
    parameter int WR_HIGH = 8,
    parameter int RD_LOW  = 14,
    parameter int RD_HIGH = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_erase,
    input  logic               req_toggle,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_data,
    input  logic [LIMIT_W-1:0] poll_limit,
    output logic               busy,
    output logic               done,
    output logic               pass,
    output logic [ADDR_W-1:0]  fl_addr,
    output logic [DATA_W-1:0]  fl_dq_out,
    output logic               fl_dq_oe,
    input  logic [DATA_W-1:0]  fl_dq_in,
    output logic               fl_ce_n,
    output logic               fl_we_n,
    output logic               fl_oe_n
);

    top_st_t            st;
    logic               op_erase, op_tog;
    logic [ADDR_W-1:0]  op_addr;
    logic [DATA_W-1:0]  op_data;
    logic [LIMIT_W-1:0] op_limit;
    logic [2:0]         idx;
    logic               done_q, pass_q;

    logic               bus_start, bus_idle, bus_ack;
    logic [ADDR_W-1:0]  bus_addr;
    logic [DATA_W-1:0]  bus_wdata, bus_rdata;
    logic               jud_rd_start, jud_fin, jud_pass;
    logic               last_step;

    assign last_step = (idx == step_count(op_erase) - 3'd1);

    // Operand mux for the bus engine (sampled only on a start pulse).
    always_comb begin
        bus_start = (st == T_CMD_GO) || (st == T_RST_GO) || jud_rd_start;
        bus_addr  = op_addr;
        bus_wdata = RESET_CMD;
        if (st == T_RST_GO) begin
            bus_addr = '0;
        end else if (st == T_CMD_GO) begin
            if (!op_erase && last_step) begin
                bus_wdata = op_data;
            end else begin
                bus_addr  = ADDR_W'(step_addr(idx));
                bus_wdata = step_data(op_erase, idx);
            end
        end
    end

    // Request sequencing: command writes, polling, recovery, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= T_IDLE;
            op_erase <= 1'b0;
            op_tog   <= 1'b0;
            op_addr  <= '0;
            op_data  <= '0;
            op_limit <= '0;
            idx      <= '0;
            done_q   <= 1'b0;
            pass_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                T_IDLE: if (req_valid) begin
                    st       <= T_CMD_GO;
                    op_erase <= req_erase;
                    op_tog   <= req_toggle;
                    op_addr  <= req_addr;
                    op_data  <= req_data;
                    op_limit <= poll_limit;
                    idx      <= '0;
                end
                T_CMD_GO:   st <= T_CMD_WAIT;
                T_CMD_WAIT: if (bus_ack) begin
                    if (last_step) begin
                        st <= T_POLL_GO;
                    end else begin
                        idx <= idx + 3'd1;
                        st  <= T_CMD_GO;
                    end
                end
                T_POLL_GO:   st <= T_POLL_WAIT;
                T_POLL_WAIT: if (jud_fin) begin
                    if (jud_pass) begin
                        st     <= T_IDLE;
                        done_q <= 1'b1;
                        pass_q <= 1'b1;
                    end else begin
                        st <= T_RST_GO;
                    end
                end
                T_RST_GO:   st <= T_RST_WAIT;
                default: if (bus_ack) begin
                    st     <= T_IDLE;
                    done_q <= 1'b1;
                    pass_q <= 1'b0;
                end
            endcase
        end
    end

    assign busy = (st != T_IDLE);
    assign done = done_q;
    assign pass = pass_q;

    flash_bus_cycle #(
        .ADDR_W(ADDR_W), .WR_LOW(WR_LOW), .WR_HIGH(WR_HIGH),
        .RD_LOW(RD_LOW), .RD_HIGH(RD_HIGH)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .start(bus_start), .is_rd(jud_rd_start),
        .addr(bus_addr), .wdata(bus_wdata), .idle(bus_idle), .ack(bus_ack),
        .rdata(bus_rdata), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
        .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    flash_poll_judge #(.LIMIT_W(LIMIT_W)) u_judge (
        .clk(clk), .rst_n(rst_n), .start(st == T_POLL_GO),
        .toggle_mode(op_tog), .exp7(op_erase | op_data[7]), .limit(op_limit),
        .rd_start(jud_rd_start), .rd_ack(bus_ack), .rd_data(bus_rdata),
        .fin(jud_fin), .fin_pass(jud_pass)
    );

    a_r1_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> bus_idle);
    a_r1_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> ($stable(op_addr) && $stable(op_erase)));
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_pass_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(pass));
    a_r7_reset_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> ($past(fl_ce_n) && !$past(fl_dq_oe)));

endmodule

// File: tb/flash_op_ctrl_bench.sv
// Scoreboard bench: the driver queues expected writes and verdicts; the
// monitor, with a scripted flash model, pops and compares them.
module flash_op_ctrl_bench;

    localparam int AW = 16;
    localparam int LW = 16;
    localparam int WRL = 10;
    localparam int WRH = 8;
    localparam int BIG = 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_erase = 1'b0, req_toggle = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic [LW-1:0] poll_limit = '0;
    logic          busy, done, pass;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dq_out, fl_dq_in;
    logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

    always #2 clk = ~clk;

    flash_op_ctrl u_flash_op_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
        .req_toggle(req_toggle), .req_addr(req_addr), .req_data(req_data),
        .poll_limit(poll_limit), .busy(busy), .done(done), .pass(pass),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    int n_chk = 0, n_err = 0, n_done = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard queues: {addr, data} writes and {pass, reads} verdicts.
    logic [AW+7:0] exp_wq[$];
    logic [16:0]   exp_rq[$];

    // Flash model configuration.
    int         busy_reads = 0, err_from = BIG, rd_cnt = 0;
    logic       m_exp7 = 1'b0;
    logic [7:0] m_final = 8'hFF;
    logic [AW-1:0] m_poll_addr = '0;

    always_comb begin
        if (rd_cnt < busy_reads)
            fl_dq_in = {~m_exp7, rd_cnt[0], (rd_cnt >= err_from), 5'b0};
        else
            fl_dq_in = m_final;
    end

    // Monitor: timing, write scoreboard, read counting, verdicts.
    int         wl = 0, wh = 0;
    bit         in_op_write = 0, bad_strobe = 0, bad_rd_addr = 0, bad_stable = 0;
    logic       prev_we = 1'b1, prev_oe = 1'b1, prev_done = 1'b0, held_pass = 1'b0;
    logic [AW+7:0] cap;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!fl_we_n) begin
                if (prev_we) begin
                    cap = {fl_addr, fl_dq_out};
                    if (in_op_write)
                        chk(wh >= WRH, "R4 write recovery", wh, WRH);
                end
                wl++;
                if (!fl_oe_n || fl_ce_n || {fl_addr, fl_dq_out} != cap) bad_strobe = 1;
            end else begin
                wh++;
            end
            if (fl_we_n && !prev_we) begin
                chk(wl == WRL, "R4 strobe width", wl, WRL);
                chk(!bad_strobe, "R4 strobe stability", bad_strobe, 0);
                bad_strobe = 0;
                if (exp_wq.size() == 0) begin
                    chk(0, "R1 unexpected write", cap, 0);
                end else begin
                    logic [AW+7:0] e;
                    e = exp_wq.pop_front();
                    chk(cap == e, "R2/R3/R7 write addr+data", cap, e);
                end
                wl = 0;
                wh = 0;
                in_op_write = 1;
            end
            if (!fl_oe_n && prev_oe && fl_addr != m_poll_addr) bad_rd_addr = 1;
            if (fl_oe_n && !prev_oe) rd_cnt++;
            if (done) begin
                chk(!prev_done, "R9 done single pulse", prev_done, 0);
                if (exp_rq.size() == 0) begin
                    chk(0, "R1 unexpected done", 1, 0);
                end else begin
                    logic [16:0] r;
                    r = exp_rq.pop_front();
                    chk(pass == r[16], "R5/R6/R8 verdict", pass, r[16]);
                    chk(rd_cnt == int'(r[15:0]), "R5/R6/R8 status read count", rd_cnt, r[15:0]);
                end
                chk(!bad_rd_addr, "R5 poll address", bad_rd_addr, 0);
                bad_rd_addr = 0;
                held_pass = pass;
                in_op_write = 0;
                n_done++;
            end else if (prev_done === 1'b1 || n_done > 0) begin
                if (pass != held_pass) bad_stable = 1;
            end
            prev_we = fl_we_n;
            prev_oe = fl_oe_n;
            prev_done = done;
        end
    end

    // Driver: queue expectations, configure the model, issue the request.
    task automatic run_op(input bit erase, input bit tog, input logic [AW-1:0] a,
                          input logic [7:0] d, input int limit, input int k, input int e,
                          input bit exp_pass, input int exp_reads, input bit poke);
        int target;
        if (erase) begin
            exp_wq.push_back({16'h0555, 8'hAA});
            exp_wq.push_back({16'h02AA, 8'h55});
            exp_wq.push_back({16'h0555, 8'h80});
            exp_wq.push_back({16'h0555, 8'hAA});
            exp_wq.push_back({16'h02AA, 8'h55});
            exp_wq.push_back({16'h0555, 8'h10});
        end else begin
            exp_wq.push_back({16'h0555, 8'hAA});
            exp_wq.push_back({16'h02AA, 8'h55});
            exp_wq.push_back({16'h0555, 8'hA0});
            exp_wq.push_back({a, d});
        end
        if (!exp_pass) exp_wq.push_back({16'h0000, 8'hF0});   // R7
        exp_rq.push_back({exp_pass, 16'(exp_reads)});
        busy_reads = k;
        err_from = e;
        rd_cnt = 0;
        m_exp7 = erase ? 1'b1 : d[7];
        m_final = erase ? 8'hFF : d;
        m_poll_addr = a;
        target = n_done + 1;
        @(negedge clk);
        req_valid = 1'b1; req_erase = erase; req_toggle = tog;
        req_addr = a; req_data = d; poll_limit = LW'(limit);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R1 busy after accept", busy, 1);
        if (poke) begin
            repeat (30) @(negedge clk);
            req_valid = 1'b1; req_erase = ~erase; req_addr = a ^ 16'h00FF; req_data = ~d;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait (n_done == target);
        @(negedge clk);
        chk(busy == 1'b0, "R1 idle after done", busy, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!busy && !done && !pass, "R10 reset status", {busy, done, pass}, 0);
        chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R10 reset bus",
            {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R5 program, polarity, completes after three busy reads
        run_op(0, 0, 16'h1234, 8'h5A, 50, 3, BIG, 1, 4, 0);
        // R5 R7 program, polarity, error persists: confirm read fails
        run_op(0, 0, 16'hBEEF, 8'hC3, 50, BIG, 2, 0, 4, 0);
        // R5 race: error flag one read before completion -> pass
        run_op(0, 0, 16'h0F0F, 8'h3C, 50, 2, 1, 1, 3, 0);
        // R6 R3 erase, toggle, two toggling pairs then stable
        run_op(1, 1, 16'h7777, 8'h00, 50, 4, BIG, 1, 6, 0);
        // R6 R7 erase, toggle, error with continued toggling
        run_op(1, 1, 16'h0001, 8'h00, 50, BIG, 0, 0, 4, 0);
        // R6 race: toggle program, error seen, next pair stable
        run_op(0, 1, 16'h4321, 8'h96, 50, 2, 1, 1, 4, 0);
        // R8 timeout: busy forever, no error, budget of 8 reads
        run_op(0, 0, 16'h5555, 8'h11, 8, BIG, BIG, 0, 8, 0);
        // R1 R5 erase polarity with a request poked while busy
        run_op(1, 0, 16'hA5A5, 8'h00, 50, 2, BIG, 1, 3, 1);
        // R6 boundary: device already finished, one pair suffices
        run_op(0, 1, 16'hFFFF, 8'h80, 50, 0, BIG, 1, 2, 0);
        chk(exp_wq.size() == 0, "R1 R2 R3 pending writes", exp_wq.size(), 0);
        chk(exp_rq.size() == 0, "R9 pending verdicts", exp_rq.size(), 0);
        chk(!bad_stable, "R9 pass stable between pulses", bad_stable, 0);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", n_done, 9);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule